// File: doc/BRIEF.md
# Maskable Status-Change Interrupt Generator

This block watches a vector of status bits coming from the rest of a transceiver. It raises an interrupt when any bit that is not masked has moved away from the value it held at the last management read. It keeps a snapshot of the status vector. The snapshot is refreshed by a one-cycle read-done pulse from the management slave, and the same pulse clears any pending interrupt. A bit that changes and then returns to its old value still leaves the interrupt pending, because the interrupt is sticky until the next read.

The pending interrupt is reported on three indicators that move together:

- an active-low interrupt pin;
- an active-high flag meant for the status register;
- a one-cycle request asking the serial slave to pull its data line low.

The block issues that request once for each new interrupt, and only while the slave reports that the bus is idle. If the bus is busy, the request waits until the bus goes idle or a read cancels it.

All ports are plain level or pulse control signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. Serial framing and register storage sit outside the block.

Top module: `stat_irq_gen`

## Requirements
- R1: The status inputs pass through SYNC_STAGES flip-flops (default 2) before they are compared. A change on stat_i that is sampled at clock edge k shows on int_bit_o after edge k+2 and not earlier.
- R2: int_bit_o becomes 1 when any unmasked bit of the synchronized status differs from the snapshot. It stays 1 until a read, even if the bit returns to its snapshot value.
- R3: mask_i bit i = 1 stops status bit i from raising the interrupt, and bit i = 0 lets it raise it. The mask is applied continuously, so clearing a mask bit while its status bit differs from the snapshot raises the interrupt.
- R4: When rd_done_i is sampled high, the snapshot takes the current synchronized status and int_bit_o is 0 from the next cycle.
- R5: Suppose a change on stat_i is sampled at edge k and rd_done_i is sampled at edge k+2, the first cycle in which the comparison sees the change. The new value goes into the snapshot and no interrupt is raised for it.
- R6: irq_n_o is always the inverse of int_bit_o (pin active-low, flag active-high).
- R7: For each new interrupt, mdio_pulse_o is high for exactly one cycle, in a cycle that follows a cycle with bus_idle_i = 1. With bus_idle_i already 1, it is high in the cycle after edge k+3. While bus_idle_i is 0 the request waits.
- R8: After reset, for SYNC_STAGES+1 cycles, the snapshot follows the synchronized status and no interrupt can be raised. A status value held steady through reset therefore produces no interrupt. The first change after that window does produce one.
- R9: A read that happens while the pulse request is still waiting for an idle bus cancels the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (management clock domain) |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_i | input | STAT_W | Raw status vector, may be asynchronous |
| mask_i | input | STAT_W | Per-bit interrupt mask, 1 = blocked |
| rd_done_i | input | 1 | One-cycle pulse at the end of a status read |
| bus_idle_i | input | 1 | Serial bus is idle and the data line may be driven |
| irq_n_o | output | 1 | Interrupt pin, active low |
| int_bit_o | output | 1 | Interrupt flag for the status register, active high |
| mdio_pulse_o | output | 1 | One-cycle request to drive the data line low |

## Verification
The bench builds the block with STAT_W = 8 and SYNC_STAGES = 2. An eight-bit vector is wide enough that mask patterns can block the high half, block the low half or block a single bit, while other bits still differ. Two synchronizer stages make the three-edge path to the interrupt and the four-edge path to the pulse short enough to check cycle by cycle. The same stage count puts the read-collision case of R5 at a fixed two-edge offset that the bench can hit exactly.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;

  typedef enum logic [0:0] {
    PG_IDLE  = 1'b0,
    PG_ARMED = 1'b1
  } pulse_st_e;

  function automatic int init_cycles(input int sync_stages);
    return sync_stages + 1;
  endfunction

endpackage

// File: rtl/stat_sync.sv
module stat_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/chg_tracker.sv
module chg_tracker
  import stat_irq_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_s_i,
  input  logic [W-1:0] mask_i,
  input  logic         rd_done_i,
  output logic         pending_o,
  output logic         new_irq_o
);

  localparam int INIT_CYC = init_cycles(SYNC_STAGES);
  localparam int CW       = $clog2(INIT_CYC + 1);

  logic [W-1:0]  snap_q;
  logic [CW-1:0] init_q;
  logic          pend_q;
  logic          in_init;
  logic [W-1:0]  diff_live;
  logic          raise;

  assign in_init   = (init_q != '0);
  assign diff_live = (stat_s_i ^ snap_q) & ~mask_i;
  assign raise     = !in_init && !rd_done_i && (|diff_live);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= CW'(INIT_CYC);
      snap_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (in_init) init_q <= init_q - 1'b1;
      if (in_init || rd_done_i) snap_q <= stat_s_i;
      if (rd_done_i)  pend_q <= 1'b0;
      else if (raise) pend_q <= 1'b1;
    end
  end

  assign pending_o = pend_q;
  assign new_irq_o = raise && !pend_q;

  a_r4_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done_i |=> !pending_o);

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && !rd_done_i) |=> pending_o);

  a_r8_quiet_init: assert property (@(posedge clk) disable iff (!rst_n)
    in_init |=> !$rose(pending_o));

endmodule

// File: rtl/mdio_pulse_gen.sv
module mdio_pulse_gen
  import stat_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic new_irq_i,
  input  logic clr_i,
  input  logic bus_idle_i,
  output logic pulse_o
);

  pulse_st_e st_q;
  logic      pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PG_IDLE;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      case (st_q)
        PG_IDLE: if (new_irq_i) st_q <= PG_ARMED;
        PG_ARMED: begin
          if (clr_i) begin
            st_q <= PG_IDLE;
          end else if (bus_idle_i) begin
            pulse_q <= 1'b1;
            st_q    <= PG_IDLE;
          end
        end
        default: st_q <= PG_IDLE;
      endcase
    end
  end

  assign pulse_o = pulse_q;

  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  a_r7_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(bus_idle_i));

endmodule

// File: rtl/stat_irq_gen.sv
module stat_irq_gen #(
  parameter int STAT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              rd_done_i,
  input  logic              bus_idle_i,
  output logic              irq_n_o,
  output logic              int_bit_o,
  output logic              mdio_pulse_o
);

  logic [STAT_W-1:0] stat_s;
  logic              pending;
  logic              new_irq;

  stat_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (stat_i),
    .q_o   (stat_s)
  );

  chg_tracker #(.W(STAT_W), .SYNC_STAGES(SYNC_STAGES)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_s_i  (stat_s),
    .mask_i    (mask_i),
    .rd_done_i (rd_done_i),
    .pending_o (pending),
    .new_irq_o (new_irq)
  );

  mdio_pulse_gen u_pls (
    .clk        (clk),
    .rst_n      (rst_n),
    .new_irq_i  (new_irq),
    .clr_i      (rd_done_i),
    .bus_idle_i (bus_idle_i),
    .pulse_o    (mdio_pulse_o)
  );

  assign int_bit_o = pending;
  assign irq_n_o   = ~pending;

  a_r7_pulse_with_int: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_pulse_o |-> int_bit_o);

  a_r6_pin_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_o) |-> $rose(int_bit_o));

endmodule

// File: tb/stat_irq_gen_test.sv
module stat_irq_gen_test;

  localparam int W = 8;

  typedef struct packed {
    logic [W-1:0] base;
    logic [W-1:0] next;
    logic [W-1:0] mask;
    logic         exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{base: 8'h00, next: 8'h01, mask: 8'h00, exp: 1'b1},
    '{base: 8'h00, next: 8'h01, mask: 8'h01, exp: 1'b0},
    '{base: 8'h00, next: 8'h03, mask: 8'h01, exp: 1'b1},
    '{base: 8'hFF, next: 8'h7F, mask: 8'h7F, exp: 1'b1},
    '{base: 8'hFF, next: 8'h7F, mask: 8'h80, exp: 1'b0},
    '{base: 8'h5A, next: 8'h5A, mask: 8'h00, exp: 1'b0},
    '{base: 8'h3C, next: 8'hC3, mask: 8'hFF, exp: 1'b0},
    '{base: 8'h3C, next: 8'hC3, mask: 8'hF0, exp: 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] stat = '0;
  logic [W-1:0] mask = '0;
  logic         rd_done = 1'b0;
  logic         bus_idle = 1'b0;
  logic         irq_n, int_bit, mdio_pulse;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  stat_irq_gen #(.STAT_W(W), .SYNC_STAGES(2)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .stat_i       (stat),
    .mask_i       (mask),
    .rd_done_i    (rd_done),
    .bus_idle_i   (bus_idle),
    .irq_n_o      (irq_n),
    .int_bit_o    (int_bit),
    .mdio_pulse_o (mdio_pulse)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_read();
    rd_done = 1'b1;
    tick(1);
    rd_done = 1'b0;
  endtask

  initial begin
    int pcount;
    // R8: status held steady through reset yields no interrupt
    stat = 8'hA5;
    tick(3);
    rst_n = 1'b1;
    tick(10);
    check("R8 int after reset", int_bit, 0);
    check("R8 pin after reset", irq_n, 1);
    check("R8 pulse after reset", mdio_pulse, 0);

    // R1: exact latency with the bus idle, R7 pulse timing
    bus_idle = 1'b1;
    stat = 8'hA4;
    tick(2);
    check("R1 not yet", int_bit, 0);
    tick(1);
    check("R1 int raised", int_bit, 1);
    check("R6 pin low", irq_n, 0);
    check("R7 no pulse yet", mdio_pulse, 0);
    tick(1);
    check("R7 pulse", mdio_pulse, 1);
    tick(1);
    check("R7 pulse one cycle", mdio_pulse, 0);
    pcount = 0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      if (mdio_pulse) pcount++;
    end
    check("R7 once per interrupt", pcount, 0);
    do_read();
    check("R4 cleared by read", int_bit, 0);
    check("R6 pin released", irq_n, 1);

    // Table walk: R2, R3, R4, R6
    bus_idle = 1'b0;
    for (int v = 0; v < NV; v++) begin
      mask = VEC[v].mask;
      stat = VEC[v].base;
      tick(4);
      do_read();
      check("R4 baseline clear", int_bit, 0);
      stat = VEC[v].next;
      tick(4);
      check("R2/R3 table int", int_bit, int'(VEC[v].exp));
      check("R6 table pin", irq_n, int'(!VEC[v].exp));
      do_read();
    end

    // R2: sticky after the bit returns
    mask = 8'h00;
    stat = 8'h10;
    tick(4);
    do_read();
    stat = 8'h11;
    tick(4);
    stat = 8'h10;
    tick(5);
    check("R2 sticky", int_bit, 1);
    do_read();
    check("R4 clear", int_bit, 0);

    // R3: unmasking a differing bit raises the interrupt
    mask = 8'h02;
    stat = 8'h12;
    tick(5);
    check("R3 masked quiet", int_bit, 0);
    mask = 8'h00;
    tick(1);
    check("R3 unmask raises", int_bit, 1);
    do_read();

    // R5: change reaches comparison in the same cycle as the read
    tick(2);
    stat = 8'h32;
    tick(2);
    do_read();
    tick(6);
    check("R5 absorbed change", int_bit, 0);

    // R7: pulse waits for idle bus
    stat = 8'h33;
    tick(8);
    check("R7 int while busy", int_bit, 1);
    check("R7 no pulse while busy", mdio_pulse, 0);
    bus_idle = 1'b1;
    pcount = 0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      if (mdio_pulse) pcount++;
    end
    check("R7 one pulse when idle", pcount, 1);
    do_read();

    // R9: read cancels a waiting request
    bus_idle = 1'b0;
    stat = 8'h37;
    tick(5);
    do_read();
    bus_idle = 1'b1;
    pcount = 0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      if (mdio_pulse) pcount++;
    end
    check("R9 cancelled pulse", pcount, 0);
    check("R9 int clear", int_bit, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule